// File: doc/BRIEF.md
# I2C Read-Only Serial Memory Target

This block is an I2C target that answers read accesses to a byte-wide internal array. A bus controller reaches it with a control byte that carries a fixed device tag, a half-select bit, two chip-select bits and the direction bit. Three kinds of read are served. A current-address read returns the byte at the internal pointer. A random read first writes a two-byte word address and then issues a repeated Start followed by a read. A sequential read continues any read for as long as the controller acknowledges each byte.

The pointer survives between transactions. It always names the next byte to be sent, and it steps through one half of the array only: the top pointer bit picks the half and is never changed by stepping. The array is filled through a separate preload port. No data bytes are written into the array from the bus. The serial lines are oversampled by a fast system clock, and SDA is presented as an input, an output value and an output enable that the pad turns into an open-drain driver.

Top module: `i2c_rdmem_target`

## Requirements
- R1: After reset the target does not drive SDA (`sda_oe` low) and the pointer is 0, so a first current-address read with half bit 0 returns the byte at address 0.
- R2: The target accepts a control byte only when bits 7..4 are 1010 and bits 2..1 equal `dev_sel`. It then drives SDA low during the ninth clock. Otherwise it leaves SDA released for the whole transaction, does not acknowledge, and leaves the pointer unchanged.
- R3: SDA falling while SCL is high (Start) restarts control-byte reception from bit 0 at any bit position and releases SDA. SDA rising while SCL is high (Stop) releases SDA and idles the target.
- R4: A control byte with bit 0 = 0 is followed by a word address sent high byte first, and each address byte is acknowledged. The pointer offset takes the low ADDR_W-1 bits of that 16-bit word and ignores the rest. A repeated Start followed by a read control byte then returns the byte at that address.
- R5: Bit 3 of every accepted control byte is written into the top pointer bit, so it selects the half in which reads and pointer steps take place.
- R6: Data bits go out most significant bit first and change only while SCL is low. SDA is released during the controller's acknowledge bit.
- R7: A controller ACK (SDA low in the ninth clock) makes the target send the byte at the next address. A NACK followed by Stop ends the read with SDA released.
- R8: The pointer advances by one after every byte sent, including the last byte, which is not acknowledged. A later current-address read therefore continues after the last byte read.
- R9: Stepping keeps the top pointer bit and wraps the offset from all ones to zero, so a burst stays inside one half.
- R10: A preload write (`pre_we` high) stores `pre_data` at `pre_addr`, and later reads from that address return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_o | output | 1 | Value to place on SDA while enabled |
| sda_oe | output | 1 | SDA output enable |
| dev_sel | input | 2 | Static chip-select strap compared with control bits 2..1 |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | ADDR_W | Preload address |
| pre_data | input | 8 | Preload data byte |

## Verification
The bench builds the target with ADDR_W = 9, which gives 256-byte halves. At that size both wrap points (0x0FF back to 0x000 and 0x1FF back to 0x100) are reached with bursts of a few bytes. It also means the upper bits of the 16-bit word address lie outside the pointer, so the bench can send nonzero high bytes and confirm they are dropped. SYNC_STAGES keeps its default of 2, and the bench holds each SCL phase long enough for that synchronizer latency to settle before the controller samples.

// File: rtl/i2c_rdmem_pkg.sv
package i2c_rdmem_pkg;

    // Fixed device tag carried in control bits 7..4
    localparam logic [3:0] DEV_TAG = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_CTRL     = 4'd1,
        ST_CTRL_ACK = 4'd2,
        ST_AHI      = 4'd3,
        ST_AHI_ACK  = 4'd4,
        ST_ALO      = 4'd5,
        ST_ALO_ACK  = 4'd6,
        ST_TX       = 4'd7,
        ST_TX_ACK   = 4'd8
    } rd_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_sh   = {sync_q.scl_sh[SYNC_STAGES-2:0], scl_i};
        sync_d.sda_sh   = {sync_q.sda_sh[SYNC_STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl_sh[SYNC_STAGES-1];
        sync_d.sda_prev = sync_q.sda_sh[SYNC_STAGES-1];
    end

    // Idle bus lines are pulled high, so every stage resets to one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_s     = sync_q.scl_sh[SYNC_STAGES-1];
    assign sda_s     = sync_q.sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_s & sync_q.scl_prev;
    assign start_det = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/rdmem_store.sv
module rdmem_store #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/rdmem_ptr_step.sv
module rdmem_ptr_step #(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_next
);

    localparam int OFF_W = ADDR_W - 1;

    logic [OFF_W-1:0] off_next;

    // Only the offset counts; the half bit is carried through untouched
    always_comb begin
        off_next = ptr[OFF_W-1:0] + 1'b1;
        ptr_next = {ptr[ADDR_W-1], off_next};
    end

endmodule

// File: rtl/i2c_rdmem_target.sv
module i2c_rdmem_target
    import i2c_rdmem_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    input  logic [1:0]        dev_sel,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [7:0]        pre_data
);

    localparam int TOP   = ADDR_W - 1;
    localparam int OFF_W = ADDR_W - 1;

    typedef struct packed {
        rd_state_e         state;
        logic [3:0]        bitcnt;
        logic [7:0]        shreg;
        logic              rw;
        logic              blk;
        logic [7:0]        ahi;
        logic [ADDR_W-1:0] ptr;
        logic              drive;
        logic              dbit;
        logic              mack;
    } regs_t;

    regs_t d, q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] ptr_next;
    logic              ptr_inc;
    logic [15:0]       word_addr;
    rd_state_e         cur_state;
    logic [ADDR_W-1:0] cur_ptr;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    rdmem_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (pre_we),
        .wr_addr (pre_addr),
        .wr_data (pre_data),
        .rd_addr (q.ptr),
        .rd_data (rd_data)
    );

    rdmem_ptr_step #(.ADDR_W(ADDR_W)) u_step (
        .ptr      (q.ptr),
        .ptr_next (ptr_next)
    );

    assign word_addr = {q.ahi, q.shreg};

    // Word-address bits above the pointer offset are accepted and dropped
    generate
        if (OFF_W < 16) begin : g_drop_hi
            logic unused_word_hi;
            assign unused_word_hi = ^word_addr[15:OFF_W];
        end
    endgenerate

    always_comb begin
        d       = q;
        ptr_inc = 1'b0;
        if (start_det) begin
            d.state  = ST_CTRL;
            d.bitcnt = '0;
            d.drive  = 1'b0;
            d.dbit   = 1'b1;
        end else if (stop_det) begin
            d.state = ST_IDLE;
            d.drive = 1'b0;
            d.dbit  = 1'b1;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                end
                ST_CTRL, ST_AHI, ST_ALO: begin
                    if (scl_rise && (q.bitcnt < 4'd8)) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && (q.bitcnt == 4'd8)) begin
                        d.bitcnt = '0;
                        if (q.state == ST_CTRL) begin
                            if ((q.shreg[7:4] == DEV_TAG) && (q.shreg[2:1] == dev_sel)) begin
                                d.state    = ST_CTRL_ACK;
                                d.rw       = q.shreg[0];
                                d.blk      = q.shreg[3];
                                d.ptr[TOP] = q.shreg[3];
                                d.drive    = 1'b1;
                                d.dbit     = 1'b0;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else if (q.state == ST_AHI) begin
                            d.ahi   = q.shreg;
                            d.state = ST_AHI_ACK;
                            d.drive = 1'b1;
                            d.dbit  = 1'b0;
                        end else begin
                            d.ptr   = {q.blk, word_addr[OFF_W-1:0]};
                            d.state = ST_ALO_ACK;
                            d.drive = 1'b1;
                            d.dbit  = 1'b0;
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        d.bitcnt = '0;
                        if (q.rw) begin
                            d.state = ST_TX;
                            d.shreg = rd_data;
                            d.drive = 1'b1;
                            d.dbit  = rd_data[7];
                        end else begin
                            d.state = ST_AHI;
                            d.drive = 1'b0;
                            d.dbit  = 1'b1;
                        end
                    end
                end
                ST_AHI_ACK, ST_ALO_ACK: begin
                    if (scl_fall) begin
                        d.state = (q.state == ST_AHI_ACK) ? ST_ALO : ST_IDLE;
                        d.drive = 1'b0;
                        d.dbit  = 1'b1;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd7) begin
                            d.state = ST_TX_ACK;
                            d.drive = 1'b0;
                            d.dbit  = 1'b1;
                            d.ptr   = ptr_next;
                            ptr_inc = 1'b1;
                        end else begin
                            d.bitcnt = q.bitcnt + 4'd1;
                            d.shreg  = {q.shreg[6:0], 1'b0};
                            d.dbit   = q.shreg[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.state  = ST_TX;
                            d.bitcnt = '0;
                            d.shreg  = rd_data;
                            d.drive  = 1'b1;
                            d.dbit   = rd_data[7];
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                default: begin
                    d.state = ST_IDLE;
                    d.drive = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.dbit <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.drive;
    assign sda_o     = q.dbit;
    assign cur_state = q.state;
    assign cur_ptr   = q.ptr;

endmodule

// File: rtl/i2c_rdmem_chk.sv
module i2c_rdmem_chk
    import i2c_rdmem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              sda_o,
    input rd_state_e         cur_state,
    input logic [ADDR_W-1:0] cur_ptr,
    input logic              ptr_inc
);

    localparam int TOP = ADDR_W - 1;

    // R3: a Start rearms control-byte reception with SDA released
    assert_start_rearms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (cur_state == ST_CTRL) && !sda_oe);

    // R7: a Stop leaves the line released and the target idle
    assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (cur_state == ST_IDLE) && !sda_oe);

    // R6: while SCL stays high the target holds its SDA drive steady
    assert_sda_steady_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !start_det && !stop_det
         && !$past(start_det) && !$past(stop_det))
        |-> ($stable(sda_oe) && $stable(sda_o)));

    // R9: a pointer step keeps the half bit and advances the offset modulo the half
    assert_ptr_half_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_inc |=> (cur_ptr[TOP] == $past(cur_ptr[TOP]))
                 && (cur_ptr[TOP-1:0] == $past(cur_ptr[TOP-1:0]) + 1'b1));

endmodule

bind i2c_rdmem_target i2c_rdmem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .sda_o     (sda_o),
    .cur_state (cur_state),
    .cur_ptr   (cur_ptr),
    .ptr_inc   (ptr_inc)
);

// File: tb/test_i2c_rdmem_target.sv
module test_i2c_rdmem_target;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 9;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int HALF       = DEPTH / 2;
    localparam int Q          = 8;
    localparam logic [1:0] DEV = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pre_we = 1'b0;
    logic [ADDR_W-1:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic sda_o, sda_oe, sda_bus;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] model [0:DEPTH-1];

    assign sda_bus = m_sda & ~(sda_oe & ~sda_o);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_rdmem_target #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) i_i2c_rdmem_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_o    (sda_o),
        .sda_oe   (sda_oe),
        .dev_sel  (DEV),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 29 + 7) ^ ((a >> 8) * 85));
    endfunction

    function automatic int step(int a);
        return (a & HALF) | ((a + 1) & (HALF - 1));
    endfunction

    function automatic logic [7:0] ctrl(logic b, logic [1:0] cs, logic rw);
        return {4'b1010, b, cs, rw};
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic preload(int a, logic [7:0] v);
        @(negedge clk);
        pre_we   = 1'b1;
        pre_addr = a[ADDR_W-1:0];
        pre_data = v;
        model[a] = v;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~sda_bus;
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(logic give_ack, output logic [7:0] data,
                             output logic steady, output logic released);
        logic s1, s2;
        steady = 1'b1;
        data   = '0;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(Q);
            s1 = sda_bus; tick(Q);
            s2 = sda_bus;
            if (s1 != s2) steady = 1'b0;
            data = {data[6:0], s1};
            m_scl = 1'b0; tick(Q);
        end
        m_sda = ~give_ack; tick(Q);
        m_scl = 1'b1; tick(Q);
        released = ~sda_oe;
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic set_addr(logic b, logic [15:0] word);
        logic ack;
        i2c_start();
        send_byte(ctrl(b, DEV, 1'b0), ack);
        check("R4", "write control ack", ack, 1);
        send_byte(word[15:8], ack);
        check("R4", "high address ack", ack, 1);
        send_byte(word[7:0], ack);
        check("R4", "low address ack", ack, 1);
    endtask

    task automatic start_read(logic b);
        logic ack;
        i2c_start();
        send_byte(ctrl(b, DEV, 1'b1), ack);
        check("R2", "matching read control ack", ack, 1);
    endtask

    task automatic read_burst(string req, int first, int n);
        logic [7:0] data;
        logic steady, released;
        int a = first;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, data, steady, released);
            check(req, $sformatf("data at %0h", a), data, model[a]);
            check("R6", "SDA steady while SCL high", steady, 1);
            check("R6", "SDA released in controller ack bit", released, 1);
            a = step(a);
        end
        i2c_stop();
        tick(4);
        check("R7", "SDA released after Stop", sda_oe, 0);
    endtask

    task automatic t_reset();
        check("R1", "sda_oe after reset", sda_oe, 0);
        for (int a = 0; a < DEPTH; a++) preload(a, pat(a));
        start_read(1'b0);
        read_burst("R1", 0, 1);
    endtask

    task automatic t_current();
        start_read(1'b0);
        read_burst("R8", 1, 2);
    endtask

    task automatic t_random();
        set_addr(1'b0, 16'h3C40);
        start_read(1'b0);
        read_burst("R4", 'h040, 1);
        start_read(1'b0);
        read_burst("R8", 'h041, 1);
    endtask

    task automatic t_block();
        set_addr(1'b1, 16'h0020);
        start_read(1'b1);
        read_burst("R5", 'h120, 1);
        start_read(1'b0);
        read_burst("R5", 'h021, 1);
    endtask

    task automatic t_sequential();
        set_addr(1'b0, 16'h7710);
        start_read(1'b0);
        read_burst("R7", 'h010, 6);
        start_read(1'b0);
        read_burst("R8", 'h016, 1);
    endtask

    task automatic t_wrap();
        set_addr(1'b0, 16'h00FF);
        start_read(1'b0);
        read_burst("R9", 'h0FF, 3);
        set_addr(1'b1, 16'h01FE);
        start_read(1'b1);
        read_burst("R9", 'h1FE, 4);
        start_read(1'b1);
        read_burst("R9", 'h102, 1);
    endtask

    task automatic t_foreign();
        logic ack;
        i2c_start();
        send_byte(ctrl(1'b1, 2'b01, 1'b1), ack);
        check("R2", "other chip select not acked", ack, 0);
        send_byte(8'hFF, ack);
        check("R2", "no drive after foreign control", ack, 0);
        i2c_stop();
        i2c_start();
        send_byte(8'hB5, ack);
        check("R2", "wrong tag not acked", ack, 0);
        i2c_stop();
        tick(4);
        check("R2", "SDA released after foreign control", sda_oe, 0);
        start_read(1'b1);
        read_burst("R2", 'h103, 1);
    endtask

    task automatic t_abort();
        logic ack;
        i2c_start();
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        i2c_start();
        send_byte(ctrl(1'b1, DEV, 1'b1), ack);
        check("R3", "control ack after mid-byte Start", ack, 1);
        read_burst("R3", 'h104, 1);
        i2c_start();
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        i2c_stop();
        tick(4);
        check("R3", "SDA released after mid-byte Stop", sda_oe, 0);
        start_read(1'b1);
        read_burst("R3", 'h105, 1);
    endtask

    task automatic t_preload_update();
        preload('h1A0, 8'hC3);
        set_addr(1'b1, 16'h00A0);
        start_read(1'b1);
        read_burst("R10", 'h1A0, 1);
        check("R10", "model holds new byte", model['h1A0], 8'hC3);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_current();
        t_random();
        t_block();
        t_sequential();
        t_wrap();
        t_foreign();
        t_abort();
        t_preload_update();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule